// File: doc/BRIEF.md
# Interleaved memory range decoder

This block holds a small bank of programmable host-address windows. Each window is set up over a 32-bit register bus with a base, a span, a stride code, a way-count code and a list of port identifiers. Setting the window's commit bit asks the window to check its own settings. One cycle later the window either reports that it is committed or flags a commit error. Only committed windows take part in address lookup.

A lookup presents a host address for one cycle. One cycle later the block returns a result. If a window matches, the result holds the index of the matching window, the interleave position of the address inside that window, and the port identifier stored for that position. If no window matches, the result is a miss. The way count can be a power of two from 1 to 16, or 3, 6 or 12. A window that is locked while committed ignores every later write until reset, so its configuration cannot change once it is in service.

Top module: `ilv_range_decoder`

## Requirements
- R1: A read of byte address 0x0 returns the capability word. Bits 3:0 hold the window count code: 0 for one window, n/2 for an even count up to 16, and n/4+4 for larger counts. With four windows the code is 2. Bit 11 (3/6/12-way support) and bit 12 (16-way support) read 1, and all other bits read 0. With four windows the whole word is 0x1802.
- R2: Bit 1 of the word at byte address 0x4 enables decoding. It resets to 0. While it is 0, every lookup returns a miss.
- R3: Window i has a control word at 0x20+0x20*i with this layout: stride code in bits 3:0, ways code in bits 7:4, lock in bit 8, commit request in bit 9, committed in bit 10, commit error in bit 11 and host-only flag in bit 12. If the commit request is set, the codes are valid, and both base and span have their low 28 bits clear, the window sets committed on the clock edge after the write.
- R4: A commit request fails if the stride code is above 6, if the ways code is 5, 6, 7 or 11 to 15, or if base or span is not a multiple of 256 MiB. A failed request sets the commit error bit and leaves committed clear. Committed and commit error are never both set.
- R5: Any accepted write to a window's control, base or span word clears its committed and error bits. If the commit request bit is still set afterwards, the checks run again one cycle later.
- R6: While a window has both lock and committed set, writes to any of its words are ignored until reset.
- R7: A committed window matches an address a when base <= a < base+span. A window with span 0 never matches. When several windows match, the lowest index wins.
- R8: For ways code w from 0 to 4 (1, 2, 4, 8 or 16 ways), the position is ((a-base) >> (8+g)) modulo 2^w, where g is the stride code.
- R9: For ways code 8, 9 or 10 (3, 6 or 12 ways), the position is ((a-base) >> (8+g)) modulo 3*2^(w-8).
- R10: The target list is 64 bits: low word at 0x24+0x20*i, high word at 0x28+0x20*i. The port identifier output is byte (position mod 8) of this list, where byte 0 is bits 7:0 of the low word.
- R11: Each lookup produces a result exactly one cycle later. On a miss, the index, position and port outputs are 0.
- R12: Window i's base low and high words are at 0x10+0x20*i and 0x14+0x20*i, and its span low and high words are at 0x18+0x20*i and 0x1C+0x20*i. A read returns its data on the cycle after the request, and the data holds until the next read. Unmapped or misaligned addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | BUS_AW | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| look_valid | input | 1 | Lookup request strobe |
| look_addr | input | ADDR_W | Host address to decode |
| res_valid | output | 1 | Lookup result valid |
| res_miss | output | 1 | No enabled, committed window covers the address |
| res_idx | output | IDX_W | Index of the winning window |
| res_pos | output | 4 | Interleave position inside the window |
| res_port | output | 8 | Port identifier selected by the position |

## Verification
The assertions check on every clock the things that hold no matter how the windows are programmed:
- the one-cycle timing of lookup results;
- zeroed fields on a miss;
- a miss whenever decoding is disabled;
- committed and error never both set;
- a locked, committed window staying frozen.

The arithmetic needs the reference model and the directed scenarios. This covers the window match, the priority between overlapping windows, and the positions for 2, 3 and 12 ways along with the sweep over every valid code. It also covers the commit outcome for each kind of bad code or misalignment, and the proof that writes to a locked window have no effect.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int ALIGN_LSB = 28;
  localparam logic [3:0] GCODE_MAX = 4'd6;
  localparam int B_LOCK = 8;
  localparam int B_REQ = 9;
  localparam int B_DONE = 10;
  localparam int B_ERR = 11;
  localparam int B_HOST = 12;

  typedef enum logic [2:0] {
    W_BASE_LO = 3'd0,
    W_BASE_HI = 3'd1,
    W_SPAN_LO = 3'd2,
    W_SPAN_HI = 3'd3,
    W_CTRL    = 3'd4,
    W_TGT_LO  = 3'd5,
    W_TGT_HI  = 3'd6,
    W_NONE    = 3'd7
  } slot_word_e;

  typedef struct packed {
    logic        active;
    logic [63:0] base;
    logic [63:0] span;
    logic [3:0]  gcode;
    logic [3:0]  wcode;
    logic [63:0] tgts;
  } slot_view_t;

  function automatic logic gcode_ok(input logic [3:0] g);
    return g <= GCODE_MAX;
  endfunction

  function automatic logic wcode_ok(input logic [3:0] w);
    return (w <= 4'd4) || ((w >= 4'd8) && (w <= 4'd10));
  endfunction

  // capability encoding of the window count
  function automatic logic [3:0] count_code(input int n);
    if (n <= 1) return 4'd0;
    else if (n <= 16) return 4'(n / 2);
    else return 4'(n / 4 + 4);
  endfunction
endpackage

// File: rtl/ilv_dec_slot.sv
module ilv_dec_slot
  import ilv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  slot_word_e  word_sel,
  input  logic [31:0] wdata,
  output logic [31:0] rd_word,
  output slot_view_t  view,
  output logic        committed,
  output logic        fault,
  output logic        frozen
);
  logic [63:0] base_q, span_q, tgt_q;
  logic [3:0]  g_q, w_q;
  logic        lock_q, req_q, done_q, err_q, host_q;
  logic        codes_ok, align_ok;

  assign frozen    = lock_q & done_q;
  assign committed = done_q;
  assign fault     = err_q;

  always_comb begin
    codes_ok = gcode_ok(g_q) && wcode_ok(w_q);
    align_ok = (base_q[ALIGN_LSB-1:0] == '0) && (span_q[ALIGN_LSB-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      span_q <= '0;
      tgt_q  <= '0;
      g_q    <= '0;
      w_q    <= '0;
      lock_q <= 1'b0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      host_q <= 1'b0;
    end else begin
      // settle a pending commit request
      if (req_q && !done_q && !err_q) begin
        if (codes_ok && align_ok) done_q <= 1'b1;
        else err_q <= 1'b1;
      end
      // accepted writes take priority over the settle step
      if (wr_en && !frozen) begin
        unique case (word_sel)
          W_BASE_LO: begin base_q[31:0]  <= wdata; done_q <= 1'b0; err_q <= 1'b0; end
          W_BASE_HI: begin base_q[63:32] <= wdata; done_q <= 1'b0; err_q <= 1'b0; end
          W_SPAN_LO: begin span_q[31:0]  <= wdata; done_q <= 1'b0; err_q <= 1'b0; end
          W_SPAN_HI: begin span_q[63:32] <= wdata; done_q <= 1'b0; err_q <= 1'b0; end
          W_CTRL: begin
            g_q    <= wdata[3:0];
            w_q    <= wdata[7:4];
            lock_q <= wdata[B_LOCK];
            req_q  <= wdata[B_REQ];
            host_q <= wdata[B_HOST];
            done_q <= 1'b0;
            err_q  <= 1'b0;
          end
          W_TGT_LO: tgt_q[31:0]  <= wdata;
          W_TGT_HI: tgt_q[63:32] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (word_sel)
      W_BASE_LO: rd_word = base_q[31:0];
      W_BASE_HI: rd_word = base_q[63:32];
      W_SPAN_LO: rd_word = span_q[31:0];
      W_SPAN_HI: rd_word = span_q[63:32];
      W_CTRL:    rd_word = {19'b0, host_q, err_q, done_q, req_q, lock_q, w_q, g_q};
      W_TGT_LO:  rd_word = tgt_q[31:0];
      W_TGT_HI:  rd_word = tgt_q[63:32];
      default:   rd_word = '0;
    endcase
  end

  always_comb begin
    view.active = done_q;
    view.base   = base_q;
    view.span   = span_q;
    view.gcode  = g_q;
    view.wcode  = w_q;
    view.tgts   = tgt_q;
  end
endmodule

// File: rtl/ilv_dec_match.sv
module ilv_dec_match
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 52
) (
  input  slot_view_t        view,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [3:0]        pos,
  output logic [7:0]        port
);
  logic [63:0] a64, off, sh, quo;
  logic [64:0] lim;
  logic [1:0]  k, r3, low;

  always_comb begin
    a64  = 64'(addr);
    lim  = {1'b0, view.base} + {1'b0, view.span};
    hit  = view.active && (view.span != '0) && (a64 >= view.base) && ({1'b0, a64} < lim);
    off  = a64 - view.base;
    sh   = off >> ({1'b0, view.gcode} + 5'd8);
    k    = view.wcode[1:0];
    quo  = sh >> k;
    r3   = 2'(quo % 64'd3);
    low  = sh[1:0] & 2'((3'd1 << k) - 3'd1);
    if (!view.wcode[3]) begin
      // power-of-two ways: keep the low w bits of the stride index
      pos = sh[3:0] & 4'((5'd1 << view.wcode[2:0]) - 5'd1);
    end else begin
      // 3*2^k ways: (q mod 3) above the k low bits
      pos = ({2'b00, r3} << k) | {2'b00, low};
    end
    port = view.tgts[{pos[2:0], 3'b000} +: 8];
  end
endmodule

// File: rtl/ilv_range_decoder.sv
module ilv_range_decoder
  import ilv_pkg::*;
#(
  parameter  int NUM_DEC = 4,
  parameter  int ADDR_W  = 52,
  parameter  int BUS_AW  = 12,
  localparam int IDX_W   = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              look_valid,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              res_valid,
  output logic              res_miss,
  output logic [IDX_W-1:0]  res_idx,
  output logic [3:0]        res_pos,
  output logic [7:0]        res_port
);
  localparam int RI_W = BUS_AW - 5;
  localparam logic [BUS_AW-1:0] SLOT_ORG = BUS_AW'(16);
  localparam logic [BUS_AW-1:0] CAP_ADDR = BUS_AW'(0);
  localparam logic [BUS_AW-1:0] CTL_ADDR = BUS_AW'(4);
  localparam logic [31:0] CAP_WORD = {19'b0, 1'b1, 1'b1, 7'b0, count_code(NUM_DEC)};

  logic              dec_en_q;
  logic [BUS_AW-1:0] rel;
  logic [RI_W-1:0]   rel_idx;
  slot_word_e        rel_word;
  logic              in_slots;
  logic [31:0]       rd_next;

  logic [NUM_DEC-1:0] slot_we, hit_v, slot_done, slot_err, slot_frz;
  logic [31:0]        slot_rd [NUM_DEC];
  slot_view_t         views   [NUM_DEC];
  logic [3:0]         pos_a   [NUM_DEC];
  logic [7:0]         port_a  [NUM_DEC];

  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic [3:0]       win_pos;
  logic [7:0]       win_port;

  // bus address decode
  always_comb begin
    rel      = bus_addr - SLOT_ORG;
    rel_idx  = rel[BUS_AW-1:5];
    rel_word = slot_word_e'(rel[4:2]);
    in_slots = (bus_addr >= SLOT_ORG) && (rel[1:0] == 2'b00) &&
               (rel_idx < RI_W'(NUM_DEC)) && (rel_word != W_NONE);
  end

  generate
    for (genvar i = 0; i < NUM_DEC; i++) begin : g_slot
      assign slot_we[i] = bus_wr && in_slots && (rel_idx == RI_W'(i));

      ilv_dec_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (slot_we[i]),
        .word_sel  (rel_word),
        .wdata     (bus_wdata),
        .rd_word   (slot_rd[i]),
        .view      (views[i]),
        .committed (slot_done[i]),
        .fault     (slot_err[i]),
        .frozen    (slot_frz[i])
      );

      ilv_dec_match #(.ADDR_W(ADDR_W)) u_match (
        .view (views[i]),
        .addr (look_addr),
        .hit  (hit_v[i]),
        .pos  (pos_a[i]),
        .port (port_a[i])
      );
    end
  endgenerate

  // global decode enable
  always_ff @(posedge clk) begin
    if (rst) dec_en_q <= 1'b0;
    else if (bus_wr && (bus_addr == CTL_ADDR)) dec_en_q <= bus_wdata[1];
  end

  // read mux and registered read data
  always_comb begin
    rd_next = '0;
    if (bus_addr == CAP_ADDR) rd_next = CAP_WORD;
    if (bus_addr == CTL_ADDR) rd_next = {30'b0, dec_en_q, 1'b0};
    for (int i = 0; i < NUM_DEC; i++) begin
      if (in_slots && (rel_idx == RI_W'(i))) rd_next = slot_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    win_any  = 1'b0;
    win_idx  = '0;
    win_pos  = '0;
    win_port = '0;
    for (int i = NUM_DEC - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        win_any  = 1'b1;
        win_idx  = IDX_W'(i);
        win_pos  = pos_a[i];
        win_port = port_a[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_miss  <= 1'b0;
      res_idx   <= '0;
      res_pos   <= '0;
      res_port  <= '0;
    end else begin
      res_valid <= look_valid;
      if (look_valid && dec_en_q && win_any) begin
        res_miss <= 1'b0;
        res_idx  <= win_idx;
        res_pos  <= win_pos;
        res_port <= win_port;
      end else begin
        res_miss <= look_valid;
        res_idx  <= '0;
        res_pos  <= '0;
        res_port <= '0;
      end
    end
  end
endmodule

// File: rtl/ilv_range_decoder_chk.sv
module ilv_range_decoder_chk #(
  parameter int NUM_DEC = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               look_valid,
  input logic               dec_en_q,
  input logic               res_valid,
  input logic               res_miss,
  input logic [IDX_W-1:0]   res_idx,
  input logic [3:0]         res_pos,
  input logic [7:0]         res_port,
  input logic [NUM_DEC-1:0] slot_done,
  input logic [NUM_DEC-1:0] slot_err,
  input logic [NUM_DEC-1:0] slot_frz
);
  a_r11_result_follows: assert property (@(posedge clk) disable iff (rst)
    look_valid |=> res_valid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !look_valid |=> !res_valid);

  a_r11_miss_zeroed: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (res_valid && res_idx == '0 && res_pos == 4'd0 && res_port == 8'd0));

  a_r2_disabled_misses: assert property (@(posedge clk) disable iff (rst)
    (look_valid && !dec_en_q) |=> res_miss);

  a_r4_status_exclusive: assert property (@(posedge clk) disable iff (rst)
    (slot_done & slot_err) == '0);

  a_r6_frozen_sticks: assert property (@(posedge clk) disable iff (rst)
    (slot_frz != '0) |=> ((slot_frz & $past(slot_frz)) == $past(slot_frz)));
endmodule

bind ilv_range_decoder ilv_range_decoder_chk #(.NUM_DEC(NUM_DEC), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ilv_range_decoder_test.sv
module ilv_range_decoder_test;
  localparam int N = 4;
  localparam int AW = 52;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        look_valid = 1'b0;
  logic [AW-1:0] look_addr = '0;
  logic        res_valid, res_miss;
  logic [1:0]  res_idx;
  logic [3:0]  res_pos;
  logic [7:0]  res_port;

  int n_checks = 0;
  int n_fail = 0;
  bit chk_on = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ilv_range_decoder #(.NUM_DEC(N), .ADDR_W(AW), .BUS_AW(12)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .look_valid(look_valid),
    .look_addr(look_addr), .res_valid(res_valid), .res_miss(res_miss),
    .res_idx(res_idx), .res_pos(res_pos), .res_port(res_port));

  // ---------------- behavioural reference model ----------------
  longint unsigned m_base[N], m_span[N], m_tgt[N];
  int m_g[N], m_w[N];
  bit m_lock[N], m_req[N], m_done[N], m_err[N], m_host[N];
  bit m_en;
  bit e_valid, e_miss;
  int e_idx, e_pos, e_port;
  logic [31:0] e_rdata;

  function automatic bit m_codes_ok(int g, int w);
    return (g <= 6) && ((w <= 4) || (w >= 8 && w <= 10));
  endfunction

  function automatic bit m_slot_addr(int a, output int idx, output int word);
    idx = (a - 16) / 32;
    word = ((a - 16) % 32) / 4;
    return (a >= 16) && ((a - 16) % 4 == 0) && (idx < N) && (word != 7);
  endfunction

  function automatic logic [31:0] m_read(int a);
    int i, wd;
    if (a == 0) return 32'h0000_1802;
    if (a == 4) return {30'b0, m_en, 1'b0};
    if (!m_slot_addr(a, i, wd)) return 32'h0;
    case (wd)
      0: return m_base[i][31:0];
      1: return m_base[i][63:32];
      2: return m_span[i][31:0];
      3: return m_span[i][63:32];
      4: return {19'b0, m_host[i], m_err[i], m_done[i], m_req[i], m_lock[i], 4'(m_w[i]), 4'(m_g[i])};
      5: return m_tgt[i][31:0];
      default: return m_tgt[i][63:32];
    endcase
  endfunction

  task automatic m_lookup(longint unsigned a, output bit miss, output int idx, output int pos, output int port);
    longint unsigned off, stride;
    int ways;
    miss = 1; idx = 0; pos = 0; port = 0;
    if (!m_en) return;
    for (int i = 0; i < N; i++) begin
      if (m_done[i] && a >= m_base[i] && a < m_base[i] + m_span[i]) begin
        off = a - m_base[i];
        ways = (m_w[i] <= 4) ? (1 << m_w[i]) : (3 << (m_w[i] - 8));
        stride = off >> (8 + m_g[i]);
        pos = int'(stride % longint'(ways));
        port = int'((m_tgt[i] >> (8 * (pos % 8))) & 64'hFF);
        idx = i;
        miss = 0;
        return;
      end
    end
  endtask

  always @(posedge clk) begin
    bit frz[N];
    int si, sw;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_base[i] = 0; m_span[i] = 0; m_tgt[i] = 0; m_g[i] = 0; m_w[i] = 0;
        m_lock[i] = 0; m_req[i] = 0; m_done[i] = 0; m_err[i] = 0; m_host[i] = 0;
      end
      m_en = 0; e_valid = 0; e_miss = 0; e_idx = 0; e_pos = 0; e_port = 0; e_rdata = 0;
    end else begin
      e_valid = look_valid;
      if (look_valid) m_lookup(longint'(look_addr), e_miss, e_idx, e_pos, e_port);
      else begin e_miss = 0; e_idx = 0; e_pos = 0; e_port = 0; end
      if (bus_rd) e_rdata = m_read(int'(bus_addr));
      for (int i = 0; i < N; i++) frz[i] = m_lock[i] && m_done[i];
      for (int i = 0; i < N; i++) begin
        if (m_req[i] && !m_done[i] && !m_err[i]) begin
          if (m_codes_ok(m_g[i], m_w[i]) && (m_base[i] % (64'd1 << 28) == 0) &&
              (m_span[i] % (64'd1 << 28) == 0)) m_done[i] = 1;
          else m_err[i] = 1;
        end
      end
      if (bus_wr) begin
        if (int'(bus_addr) == 4) m_en = bus_wdata[1];
        else if (m_slot_addr(int'(bus_addr), si, sw) && !frz[si]) begin
          case (sw)
            0: m_base[si][31:0] = bus_wdata;
            1: m_base[si][63:32] = bus_wdata;
            2: m_span[si][31:0] = bus_wdata;
            3: m_span[si][63:32] = bus_wdata;
            4: begin
              m_g[si] = int'(bus_wdata[3:0]); m_w[si] = int'(bus_wdata[7:4]);
              m_lock[si] = bus_wdata[8]; m_req[si] = bus_wdata[9]; m_host[si] = bus_wdata[12];
            end
            5: m_tgt[si][31:0] = bus_wdata;
            default: m_tgt[si][63:32] = bus_wdata;
          endcase
          if (sw <= 4) begin m_done[si] = 0; m_err[si] = 0; end
        end
      end
    end
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      check("R11 per-cycle result valid", 64'(res_valid), 64'(e_valid));
      if (e_valid) begin
        check("R11 per-cycle miss", 64'(res_miss), 64'(e_miss));
        check("R7 per-cycle index", 64'(res_idx), 64'(e_idx));
        check("R8/R9 per-cycle position", 64'(res_pos), 64'(e_pos));
        check("R10 per-cycle port", 64'(res_port), 64'(e_port));
      end
      check("R12 per-cycle read data", 64'(bus_rdata), 64'(e_rdata));
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [11:0] wa(int i, int word);
    return 12'(16 + 32 * i + 4 * word);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic look(longint unsigned a, output logic m, output logic [1:0] ix,
                      output logic [3:0] p, output logic [7:0] pt);
    @(negedge clk); look_addr = AW'(a); look_valid = 1'b1;
    @(negedge clk); look_valid = 1'b0; m = res_miss; ix = res_idx; p = res_pos; pt = res_port;
  endtask

  task automatic setup(int i, longint unsigned b, longint unsigned s, longint unsigned t);
    wr(wa(i, 0), b[31:0]); wr(wa(i, 1), b[63:32]);
    wr(wa(i, 2), s[31:0]); wr(wa(i, 3), s[63:32]);
    wr(wa(i, 5), t[31:0]); wr(wa(i, 6), t[63:32]);
  endtask

  task automatic expect_hit(string tag, longint unsigned a, int ix, int p, int pt);
    logic m; logic [1:0] gi; logic [3:0] gp; logic [7:0] gt;
    look(a, m, gi, gp, gt);
    check({tag, " miss"}, 64'(m), 64'(0));
    check({tag, " index"}, 64'(gi), 64'(ix));
    check({tag, " position"}, 64'(gp), 64'(p));
    check({tag, " port"}, 64'(gt), 64'(pt));
  endtask

  task automatic expect_miss(string tag, longint unsigned a);
    logic m; logic [1:0] gi; logic [3:0] gp; logic [7:0] gt;
    look(a, m, gi, gp, gt);
    check({tag, " miss"}, 64'(m), 64'(1));
    check({tag, " zero port"}, 64'(gt), 64'(0));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- directed scenarios ----------------
  initial begin
    logic [31:0] d;
    int wlist[8];
    wlist = '{0, 1, 2, 3, 4, 8, 9, 10};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_on = 1;

    // R1 / R2 / R12 reset and capability
    rd(12'h000, d); check("R1 capability word", 64'(d), 64'h1802);
    rd(12'h004, d); check("R2 enable resets clear", 64'(d), 64'h0);
    rd(12'h008, d); check("R12 unmapped reads zero", 64'(d), 64'h0);
    rd(12'h090, d); check("R12 beyond last window reads zero", 64'(d), 64'h0);
    wr(12'h011, 32'hFFFF_FFFF);
    rd(12'h010, d); check("R12 misaligned write ignored", 64'(d), 64'h0);
    expect_miss("R7 nothing committed", 64'h1_0000_0100);

    // window 0: 2 ways, 256 B stride
    setup(0, 64'h1_0000_0000, 64'h4000_0000, 64'h1716_1514_1312_1110);
    wr(wa(0, 4), 32'h210);
    rd(wa(0, 4), d); check("R3 commit sets committed", 64'(d), 64'h610);
    rd(wa(0, 1), d); check("R12 base high readback", 64'(d), 64'h1);
    expect_miss("R2 disabled lookup", 64'h1_0000_0100);
    wr(12'h004, 32'h2);
    rd(12'h004, d); check("R2 enable readback", 64'(d), 64'h2);
    expect_hit("R8 two-way odd stride", 64'h1_0000_0100, 0, 1, 8'h11);
    expect_hit("R8 two-way base", 64'h1_0000_0000, 0, 0, 8'h10);
    expect_miss("R7 end is exclusive", 64'h1_4000_0000);
    expect_miss("R7 below base", 64'h0_FFFF_FFFF);

    // R4 commit failures
    wr(wa(1, 4), 32'h207);
    rd(wa(1, 4), d); check("R4 stride code 7 rejected", 64'(d), 64'hA07);
    wr(wa(2, 4), 32'h250);
    rd(wa(2, 4), d); check("R4 ways code 5 rejected", 64'(d), 64'hA50);
    setup(3, 64'h2_0000_0100, 64'h1000_0000, 64'h0);
    wr(wa(3, 4), 32'h200);
    rd(wa(3, 4), d); check("R4 misaligned base rejected", 64'(d), 64'hA00);

    // R5 / R9 three-way window 1
    setup(1, 64'h2_0000_0000, 64'h1000_0000, 64'h0000_0000_2322_2120);
    wr(wa(1, 4), 32'h282);
    rd(wa(1, 4), d); check("R5 rewrite clears error and recommits", 64'(d), 64'h682);
    expect_hit("R9 three-way", 64'h2_0000_1400, 1, 2, 8'h22);

    // R9 / R10 twelve-way window 2
    setup(2, 64'h3_0000_0000, 64'h1000_0000, 64'h3736_3534_3332_3130);
    wr(wa(2, 4), 32'h2A0);
    expect_hit("R10 twelve-way position 11", 64'h3_0000_0B00, 2, 11, 8'h33);
    expect_hit("R9 twelve-way position 1", 64'h3_0000_0D00, 2, 1, 8'h31);

    // R5 base write drops committed
    wr(wa(2, 0), 32'h0);
    rd(wa(2, 4), d); check("R5 base write recommits", 64'(d), 64'h6A0);

    // R7 priority with overlapping window 3
    setup(3, 64'h1_0000_0000, 64'h1000_0000, 64'h0000_0000_0000_00AA);
    wr(wa(3, 4), 32'h200);
    expect_hit("R7 lowest index wins", 64'h1_0000_0100, 0, 1, 8'h11);
    wr(wa(0, 4), 32'h0);
    expect_hit("R7 next window after clear", 64'h1_0000_0100, 3, 0, 8'hAA);

    // R6 lock
    wr(wa(0, 4), 32'h310);
    rd(wa(0, 4), d); check("R6 locked commit", 64'(d), 64'h710);
    wr(wa(0, 1), 32'h5);
    wr(wa(0, 4), 32'h0);
    rd(wa(0, 1), d); check("R6 base write ignored", 64'(d), 64'h1);
    rd(wa(0, 4), d); check("R6 control write ignored", 64'(d), 64'h710);
    expect_hit("R6 locked window still decodes", 64'h1_0000_0100, 0, 1, 8'h11);

    // sweep every valid ways code on window 1, model compares each cycle
    for (int r = 0; r < 8; r++) begin
      wr(wa(1, 4), 32'h200 | (32'(wlist[r]) << 4) | 32'(r % 7));
      rd(wa(1, 4), d); check("R3 sweep commit", 64'(d[10]), 64'h1);
      for (int j = 0; j < 40; j++) begin
        logic m; logic [1:0] gi; logic [3:0] gp; logic [7:0] gt;
        look(64'h2_0000_0000 + longint'($urandom % 32'h1100_0000), m, gi, gp, gt);
      end
    end

    // R2 disable again
    wr(12'h004, 32'h0);
    expect_miss("R2 disable forces miss", 64'h1_0000_0100);

    // R6 reset releases the lock
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    wr(wa(0, 4), 32'h210);
    rd(wa(0, 4), d); check("R6 writable after reset", 64'(d), 64'h610);
    rd(wa(0, 1), d); check("R6 base cleared by reset", 64'(d), 64'h0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule